// File: doc/BRIEF.md
# Drift-Free Tick and Jittered Statistics Event Scheduler

This block turns a free-running 32-bit reference count into two event streams for an operating-system clock. The first is a periodic tick at `TICK_HZ`. Its interval is the integer quotient of the reference frequency by `TICK_HZ`. An error accumulator carries the leftover remainder, so the long-run tick rate is exact. The second is a statistics tick that runs on average at a programmable rate. Each of its intervals is a fixed minimum plus a nonzero pseudo-random offset drawn from a power-of-two window, so the tick does not lock step with periodic work.

Software or a timer-interrupt sequencer pulses `serviceReq` when a one-shot timer expires. The block samples the reference count and works through every tick and every statistics event that has fallen due, one per clock cycle. Each serviced event gives one pulse. It then chooses the nearer of the two next events and reports how many counts a one-shot timer must be loaded with to reach it. If that distance is unreasonably long, it assumes time was lost, reports one tick interval and rebases both schedules. The one-shot timer itself lies outside the block.

Top module: `clock_event_sched`

## Requirements
- R1: While `rstN` is low, `tickPulse`, `statPulse`, `done` and `timeLost` are 0 and `duration` is 0. On the first clock edge after reset is released, both scheduled times are set to `refCount` plus one tick interval. The error accumulator clears, the LFSR loads its seed, and the statistics parameters take the values derived from `STAT_HZ`.
- R2: The tick interval is REF_FREQ / TICK_HZ, and the remainder REF_FREQ % TICK_HZ is added to an error accumulator on each serviced tick. When the accumulator then exceeds TICK_HZ, that tick's next time moves one count later and TICK_HZ is subtracted from the accumulator.
- R3: An event is due when (scheduled − now), taken as a signed 32-bit value, is zero or negative. Schedules that cross the 32-bit wrap of the reference count are therefore handled correctly.
- R4: In one service, every due tick is handled first, one per cycle, then every due statistics event. Each handled event gives a one-cycle pulse on `tickPulse` or `statPulse`, so a service that runs late by N tick intervals gives N tick pulses.
- R5: The statistics parameters are set from a rate S: si = REF_FREQ / S. The window w is the result of starting at 2^30 and halving while w > si/2 + 100, and the minimum is si − w/2. A `rateReq` pulse applies `rateHz` this way. It is ignored when `rateHz` is 0 or when si < w/2. A new rate takes effect on the next statistics interval that is scheduled.
- R6: Each statistics interval is the minimum plus r, where r = L & (w − 1) and L is the current LFSR state. The LFSR is 32 bits wide and reset to 1. Each draw advances it: shift right one place, then XOR with 0x80200003 when the bit shifted out was 1. A draw with r = 0 is discarded and drawn again.
- R7: After servicing, the target is the scheduled time (tick or statistics) whose unsigned distance from the sampled "now" is strictly smaller; a tie chooses the statistics time. The duration is the target minus `refCount` read again at the end of the service. A result that is zero or negative as a signed value becomes 1.
- R8: If that duration exceeds one tick interval plus one, `timeLost` pulses with `done`, `duration` reports one tick interval, and both scheduled times become the sampled "now".
- R9: `done` pulses for one cycle at the end of each service, with `duration` and `timeLost` valid in that cycle and `duration` held until the next service. A `serviceReq` that arrives while a service is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refCount | input | 32 | Free-running reference count |
| serviceReq | input | 1 | Start a service pass (one-shot expiry) |
| rateReq | input | 1 | Load a new statistics rate from `rateHz` |
| rateHz | input | RATE_W | Requested statistics rate in events per second |
| tickPulse | output | 1 | One pulse per serviced periodic tick |
| statPulse | output | 1 | One pulse per serviced statistics event |
| done | output | 1 | Service finished; `duration` and `timeLost` valid |
| timeLost | output | 1 | The service detected lost time and rebased |
| duration | output | 32 | Counts to program into the one-shot timer |

## Verification
The bench starts the reference count just below the 32-bit wrap, so the first scheduled events lie on the far side of zero. A design that compares unsigned would miss these events or fire them early. It services late by several tick intervals, where a design that handles only one event per pass would emit too few tick pulses and leave the schedule behind. It moves the reference count forward during a service to force a negative duration, which must come out as 1 and not as a huge wrapped value. It moves the count backward to force the time-lost path, where a missing rebase would keep producing lost flags. Rate requests at 0 and above the allowed limit must leave the statistics intervals unchanged. The smallest accepted window gives a zero minimum, which exposes any design that accepts a zero random draw. A long random run compares every tick count, statistics count and duration with a bench model of the accumulator and the LFSR, so a wrong carry or a misordered draw shows up within a few hundred services.

// File: rtl/clock_event_pkg.sv
package clock_event_pkg;

  localparam int TIME_W = 32;
  localparam logic [TIME_W-1:0] LFSR_TAPS = 32'h8020_0003;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_TICK,
    ST_STAT,
    ST_PICK
  } evState_t;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic loadInit;
    logic capture;
    logic stepTick;
    logic stepStat;
    logic redraw;
    logic finish;
  } evStrobe_t;

  // Largest power of two, starting from 2^30, not above statInt/2 + 100.
  function automatic logic [TIME_W-1:0] statWindow(input logic [TIME_W-1:0] statInt);
    logic [TIME_W-1:0] lim;
    logic [TIME_W-1:0] w;
    lim = (statInt >> 1) + TIME_W'(100);
    w   = TIME_W'(32'h4000_0000);
    for (int i = 0; i < 31; i++) begin
      if (w > lim) w = w >> 1;
    end
    return w;
  endfunction

endpackage

// File: rtl/clock_event_lfsr.sv
module clock_event_lfsr
  import clock_event_pkg::*;
#(
  parameter logic [TIME_W-1:0] SEED = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  output logic [TIME_W-1:0] state
);

  logic [TIME_W-1:0] stepped;

  always_comb begin
    stepped = state >> 1;
    if (state[0]) stepped = stepped ^ LFSR_TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEED;
    else if (advance) state <= stepped;
  end

  // R6: the generator never locks up in the all-zero state
  assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

endmodule

// File: rtl/clock_event_ctrl.sv
module clock_event_ctrl
  import clock_event_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      serviceReq,
  input  logic      tickDue,
  input  logic      statDue,
  input  logic      drawZero,
  output evStrobe_t strobe
);

  evState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_INIT: begin
        strobe.loadInit = 1'b1;
        stateNext       = ST_IDLE;
      end
      ST_IDLE: begin
        if (serviceReq) begin
          strobe.capture = 1'b1;
          stateNext      = ST_TICK;
        end
      end
      ST_TICK: begin
        if (tickDue) strobe.stepTick = 1'b1;
        else stateNext = ST_STAT;
      end
      ST_STAT: begin
        if (statDue) begin
          if (drawZero) strobe.redraw = 1'b1;
          else strobe.stepStat = 1'b1;
        end else begin
          stateNext = ST_PICK;
        end
      end
      ST_PICK: begin
        strobe.finish = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_INIT;
    else state <= stateNext;
  end

  // R4: statistics events are only served once no tick is left due
  assert_tick_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepStat |-> !tickDue);

  // R6: a redraw only happens on a zero draw
  assert_redraw_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.redraw |-> drawZero);

  // R9: a service request while busy never recaptures
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strobe.capture);

endmodule

// File: rtl/clock_event_dp.sv
module clock_event_dp
  import clock_event_pkg::*;
#(
  parameter int unsigned       REF_FREQ  = 32768,
  parameter int unsigned       TICK_HZ   = 100,
  parameter int unsigned       STAT_HZ   = 128,
  parameter int                RATE_W    = 16,
  parameter logic [TIME_W-1:0] LFSR_SEED = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] refCount,
  input  logic              rateReq,
  input  logic [RATE_W-1:0] rateHz,
  input  evStrobe_t         strobe,
  output logic              tickDue,
  output logic              statDue,
  output logic              drawZero,
  output logic              tickPulse,
  output logic              statPulse,
  output logic              done,
  output logic              timeLost,
  output logic [TIME_W-1:0] duration
);

  localparam logic [TIME_W-1:0] TICK_INT = TIME_W'(REF_FREQ / TICK_HZ);
  localparam logic [TIME_W-1:0] TICK_ERR = TIME_W'(REF_FREQ % TICK_HZ);
  localparam logic [TIME_W-1:0] HZ_T     = TIME_W'(TICK_HZ);
  localparam logic [TIME_W-1:0] DEF_SI   = TIME_W'(REF_FREQ / STAT_HZ);
  localparam logic [TIME_W-1:0] DEF_WIN  = statWindow(DEF_SI);
  localparam logic [TIME_W-1:0] DEF_MIN  = DEF_SI - (DEF_WIN >> 1);

  logic [TIME_W-1:0] nowReg, nextTick, nextStat, errSum;
  logic [TIME_W-1:0] statMin, statWin, lfsrState;

  // Due detection: signed difference scheduled - now
  logic [TIME_W-1:0] tickDiff, statDiff;
  assign tickDiff = nextTick - nowReg;
  assign statDiff = nextStat - nowReg;
  assign tickDue  = tickDiff[TIME_W-1] || (tickDiff == '0);
  assign statDue  = statDiff[TIME_W-1] || (statDiff == '0);

  // Random offset within the window
  logic [TIME_W-1:0] draw;
  assign draw     = lfsrState & (statWin - TIME_W'(1));
  assign drawZero = (draw == '0);

  clock_event_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk     (clk),
    .rstN    (rstN),
    .advance (strobe.stepStat | strobe.redraw),
    .state   (lfsrState)
  );

  // Tick step with remainder compensation
  logic [TIME_W-1:0] errNext, tickStep;
  logic              errCarry;
  assign errNext  = errSum + TICK_ERR;
  assign errCarry = errNext > HZ_T;
  assign tickStep = TICK_INT + (errCarry ? TIME_W'(1) : TIME_W'(0));

  // Rate change parameters
  logic [TIME_W-1:0] rateSi, rateWin, rateMin;
  logic              rateOk;
  always_comb begin
    rateSi  = (rateHz != '0) ? (TIME_W'(REF_FREQ) / TIME_W'(rateHz)) : '0;
    rateWin = statWindow(rateSi);
    rateMin = rateSi - (rateWin >> 1);
    rateOk  = (rateHz != '0) && (rateSi >= (rateWin >> 1));
  end

  // Next-event choice and duration
  logic [TIME_W-1:0] pickTarget, rawDur, clampDur;
  logic              lostNow;
  always_comb begin
    pickTarget = (tickDiff < statDiff) ? nextTick : nextStat;
    rawDur     = pickTarget - refCount;
    clampDur   = (rawDur[TIME_W-1] || rawDur == '0) ? TIME_W'(1) : rawDur;
    lostNow    = clampDur > (TICK_INT + TIME_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowReg    <= '0;
      nextTick  <= '0;
      nextStat  <= '0;
      errSum    <= '0;
      statMin   <= DEF_MIN;
      statWin   <= DEF_WIN;
      duration  <= '0;
      tickPulse <= 1'b0;
      statPulse <= 1'b0;
      done      <= 1'b0;
      timeLost  <= 1'b0;
    end else begin
      tickPulse <= strobe.stepTick;
      statPulse <= strobe.stepStat;
      done      <= strobe.finish;
      timeLost  <= strobe.finish & lostNow;

      if (strobe.loadInit) begin
        nextTick <= refCount + TICK_INT;
        nextStat <= refCount + TICK_INT;
        errSum   <= '0;
      end
      if (strobe.capture) nowReg <= refCount;
      if (strobe.stepTick) begin
        nextTick <= nextTick + tickStep;
        errSum   <= errCarry ? (errNext - HZ_T) : errNext;
      end
      if (strobe.stepStat) nextStat <= nextStat + statMin + draw;
      if (strobe.finish) begin
        duration <= lostNow ? TICK_INT : clampDur;
        if (lostNow) begin
          nextTick <= nowReg;
          nextStat <= nowReg;
        end
      end
      if (rateReq && rateOk) begin
        statMin <= rateMin;
        statWin <= rateWin;
      end
    end
  end

  // R2: each tick advances by one interval or one interval plus one
  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepTick |=> ((nextTick - $past(nextTick)) == TICK_INT) ||
                        ((nextTick - $past(nextTick)) == TICK_INT + TIME_W'(1)));

  // R2: the accumulator never exceeds the tick rate
  assert_err_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    errSum <= HZ_T);

  // R5: the window is always a single power of two
  assert_win_pow2_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(statWin) == 1);

  // R6: a statistics interval lies strictly above the minimum and below min + window
  assert_stat_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepStat |=> ((nextStat - $past(nextStat)) > $past(statMin)) &&
                        ((nextStat - $past(nextStat)) < $past(statMin) + $past(statWin)));

  // R7: a reported duration is never zero nor beyond one interval plus one
  assert_dur_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (duration != '0) && (duration <= TICK_INT + TIME_W'(1)));

  // R8: a lost-time result reports one interval and rebases both schedules together
  assert_lost_rebase_R8: assert property (@(posedge clk) disable iff (!rstN)
    timeLost |-> (duration == TICK_INT) && (nextTick == nextStat));

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/clock_event_sched.sv
module clock_event_sched
  import clock_event_pkg::*;
#(
  parameter int unsigned       REF_FREQ  = 32768,
  parameter int unsigned       TICK_HZ   = 100,
  parameter int unsigned       STAT_HZ   = 128,
  parameter int                RATE_W    = 16,
  parameter logic [TIME_W-1:0] LFSR_SEED = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       refCount,
  input  logic              serviceReq,
  input  logic              rateReq,
  input  logic [RATE_W-1:0] rateHz,
  output logic              tickPulse,
  output logic              statPulse,
  output logic              done,
  output logic              timeLost,
  output logic [31:0]       duration
);

  evStrobe_t strobe;
  logic      tickDue, statDue, drawZero;

  clock_event_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .serviceReq (serviceReq),
    .tickDue    (tickDue),
    .statDue    (statDue),
    .drawZero   (drawZero),
    .strobe     (strobe)
  );

  clock_event_dp #(
    .REF_FREQ  (REF_FREQ),
    .TICK_HZ   (TICK_HZ),
    .STAT_HZ   (STAT_HZ),
    .RATE_W    (RATE_W),
    .LFSR_SEED (LFSR_SEED)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .refCount  (refCount),
    .rateReq   (rateReq),
    .rateHz    (rateHz),
    .strobe    (strobe),
    .tickDue   (tickDue),
    .statDue   (statDue),
    .drawZero  (drawZero),
    .tickPulse (tickPulse),
    .statPulse (statPulse),
    .done      (done),
    .timeLost  (timeLost),
    .duration  (duration)
  );

endmodule

// File: tb/clock_event_sched_bench.sv
`timescale 1ns/1ps
module clock_event_sched_bench;

  localparam int unsigned FREQ  = 32768;
  localparam int unsigned HZ    = 100;
  localparam logic [31:0] TINT  = 32'd327;
  localparam logic [31:0] TERR  = 32'd68;
  localparam logic [31:0] TAPS  = 32'h8020_0003;

  logic        clk, rstN, serviceReq, rateReq;
  logic [31:0] refCount;
  logic [15:0] rateHz;
  logic        tickPulse, statPulse, done, timeLost;
  logic [31:0] duration;

  clock_event_sched u_clock_event_sched (
    .clk(clk), .rstN(rstN), .refCount(refCount), .serviceReq(serviceReq),
    .rateReq(rateReq), .rateHz(rateHz), .tickPulse(tickPulse),
    .statPulse(statPulse), .done(done), .timeLost(timeLost), .duration(duration)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mTick, mStat, mErr, mLfsr, mMin, mWin, cur;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lfsrNext(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : 32'h0);
  endfunction

  function automatic logic [31:0] winOf(input logic [31:0] si);
    logic [31:0] w = 32'h4000_0000;
    while (w > (si / 2 + 100)) w = w / 2;
    return w;
  endfunction

  function automatic bit dueAt(input logic [31:0] sched, input logic [31:0] now);
    return $signed(sched - now) <= 0;
  endfunction

  task automatic modelRate(input int unsigned v);
    logic [31:0] si, w;
    if (v == 0) return;
    si = FREQ / v;
    w  = winOf(si);
    if (si >= w / 2) begin
      mMin = si - w / 2;
      mWin = w;
    end
  endtask

  task automatic modelService(input logic [31:0] now, input logic [31:0] fresh,
                              output int t, output int s,
                              output logic [31:0] d, output logic l);
    logic [31:0] r, tgt;
    t = 0; s = 0; l = 1'b0;
    while (dueAt(mTick, now)) begin
      mTick = mTick + TINT;
      mErr  = mErr + TERR;
      if (mErr > HZ) begin
        mTick = mTick + 1;
        mErr  = mErr - HZ;
      end
      t++;
    end
    while (dueAt(mStat, now)) begin
      do begin
        r     = mLfsr & (mWin - 1);
        mLfsr = lfsrNext(mLfsr);
      end while (r == 0);
      mStat = mStat + mMin + r;
      s++;
    end
    tgt = ((mTick - now) < (mStat - now)) ? mTick : mStat;
    d   = tgt - fresh;
    if ($signed(d) <= 0) d = 1;
    if (d > TINT + 1) begin
      l     = 1'b1;
      d     = TINT;
      mTick = now;
      mStat = now;
    end
  endtask

  task automatic setRate(input int unsigned v);
    @(negedge clk);
    rateReq = 1'b1;
    rateHz  = 16'(v);
    @(negedge clk);
    rateReq = 1'b0;
    modelRate(v);
  endtask

  task automatic doService(input logic [31:0] nowV, input bit bump,
                           input logic [31:0] bumpV, input bit poke,
                           input string tag);
    int gotT = 0, gotS = 0, cyc = 0, expT, expS;
    bit seenDone = 0;
    logic [31:0] expD, sawD;
    logic expL, sawL;
    @(negedge clk);
    refCount   = nowV;
    serviceReq = 1'b1;
    @(negedge clk);
    serviceReq = 1'b0;
    if (bump) refCount = bumpV;
    while (!seenDone && cyc < 4000) begin
      if (tickPulse) gotT++;
      if (statPulse) gotS++;
      if (done) begin
        seenDone = 1;
        sawD = duration;
        sawL = timeLost;
      end else begin
        cyc++;
        if (poke && cyc == 1) serviceReq = 1'b1;
        if (poke && cyc == 2) serviceReq = 1'b0;
        @(negedge clk);
      end
    end
    check(tag, "done seen (R9)", 32'(seenDone), 32'd1);
    modelService(nowV, bump ? bumpV : nowV, expT, expS, expD, expL);
    check(tag, "tick pulses (R4)", 32'(gotT), 32'(expT));
    check(tag, "stat pulses (R6)", 32'(gotS), 32'(expS));
    check(tag, "duration (R7)", sawD, expD);
    check(tag, "timeLost (R8)", 32'(sawL), 32'(expL));
    if (poke) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        check("R9", "no extra done after busy request", 32'(done), 32'd0);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] base;
    int unsigned rates [4] = '{64, 128, 256, 1024};
    void'($urandom(32'd1234));
    base       = 32'hFFFF_FF80;
    rstN       = 1'b0;
    serviceReq = 1'b0;
    rateReq    = 1'b0;
    rateHz     = '0;
    refCount   = base;
    repeat (3) @(negedge clk);
    check("R1", "tickPulse in reset", 32'(tickPulse), 0);
    check("R1", "statPulse in reset", 32'(statPulse), 0);
    check("R1", "done in reset", 32'(done), 0);
    check("R1", "timeLost in reset", 32'(timeLost), 0);
    check("R1", "duration in reset", duration, 0);
    rstN = 1'b1;
    mTick = base + TINT; mStat = base + TINT; mErr = 0;
    mLfsr = 32'h1; mMin = 32'd192; mWin = 32'd128;
    @(negedge clk);
    check("R1", "done idle after reset", 32'(done), 0);

    // R1/R7: nothing due yet, tie picks the shared time
    cur = base;
    doService(cur, 0, 0, 0, "R1");
    // R3: scheduled times lie across the wrap
    cur = base + TINT;
    doService(cur, 0, 0, 0, "R3");
    // R4: late by several intervals
    cur = cur + 5 * TINT + 20;
    doService(cur, 0, 0, 0, "R4");
    cur = cur + 100;
    doService(cur, 0, 0, 0, "R2");
    // R5: rejected and accepted rate requests
    setRate(0);
    setRate(2048);
    cur = cur + 600;
    doService(cur, 0, 0, 0, "R5");
    setRate(64);
    for (int i = 0; i < 6; i++) begin
      cur = cur + 300;
      doService(cur, 0, 0, 0, "R5");
    end
    // R9: request while busy is ignored
    cur = cur + 10;
    doService(cur, 0, 0, 1, "R9");
    // R7: reference runs ahead during service -> duration 1
    cur = cur + 200;
    doService(cur, 1, cur + 2000, 0, "R7");
    cur = cur + 2000;
    // R8: count jumps backward -> lost time
    cur = cur - 5000;
    doService(cur, 0, 0, 0, "R8");
    doService(cur, 0, 0, 0, "R8");
    // R6: smallest window with zero minimum
    setRate(1024);
    for (int i = 0; i < 8; i++) begin
      cur = cur + 150;
      doService(cur, 0, 0, 0, "R6");
    end
    // Random mix
    for (int i = 0; i < 300; i++) begin
      int unsigned pick = $urandom_range(0, 99);
      if (pick < 8) setRate(rates[$urandom_range(0, 3)]);
      if (pick >= 95) cur = cur - $urandom_range(400, 3000);
      else cur = cur + $urandom_range(0, 900);
      if (pick >= 85 && pick < 95) begin
        logic [31:0] fr = cur + $urandom_range(0, 400);
        doService(cur, 1, fr, 0, "R2");
        cur = fr;
      end else begin
        doService(cur, 0, 0, 0, "R2");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule